// File: doc/BRIEF.md
# Valley-Switched Flyback Stroke Sequencer

This block decides when the primary switch of a quasi-resonant flyback converter turns on and off. It sees only digitised comparator results: a flag that the transformer has finished demagnetising, a flag that the drain voltage is at a valley, a peak-current trip, a short-winding trip and a one-cycle oscillator pulse. It drives one gate signal and raises a one-cycle fault pulse for the supervisor.

A stroke begins only when three things coincide: the secondary stroke has finished, the oscillator has granted a new period, and the drain sits in a valley. Once the gate is on, both trip comparators are masked for a blanking window. After that, a current trip ends the stroke and an on-time limit bounds it. After switch-off, the demagnetisation flag is masked for a suppression window so that leakage ringing cannot count as the end of demagnetisation. A short-winding trip or an expired on-time limit stops switching until the supervisor drops and raises the enable. All windows are parameters counted in clock cycles, and one down-counter times them all.

Top module: `flyback_stroke_seq`

## Requirements
- R1: While `rst` is high, and after it falls with `en` low, `gate` and `fault` are 0 whatever the sense inputs do.
- R2: When `en` is 0, `gate` is 0 in the same cycle, even in the middle of a stroke. Any stored oscillator grant is dropped, so after `en` returns a fresh `osc_ready` pulse is needed.
- R3: A one-cycle `osc_ready` pulse is held as a grant until a stroke starts. `gate` rises on the clock edge after one where the grant is held and `valley` is 1. It never rises while `valley` is 0. The first stroke after enable needs no demagnetisation flag, so with `en`, `valley` and an `osc_ready` pulse on the same edge, `gate` is high one cycle after the pulse.
- R4: After a stroke ends on a current trip, the next stroke waits for `demag_done`. With `demag_done` low, `gate` stays 0 even with a grant and a valley present. Once `demag_done` rises, `gate` rises 2 cycles later.
- R5: `demag_done` is ignored for SUPP_CYC cycles after switch-off. With demagnetisation, grant and valley all present, the gate stays low for exactly SUPP_CYC+2 cycles.
- R6: Both trip inputs are ignored for LEB_CYC cycles after `gate` rises. With `cs_trip` held high, `gate` is high for exactly LEB_CYC+1 cycles.
- R7: A current trip ends the stroke without a fault. Releasing `cs_trip` afterwards does not turn `gate` back on.
- R8: Without any trip, `gate` stays high for exactly MAXON_CYC cycles, then falls and `fault` pulses. Switching then stays halted.
- R9: A short-winding trip after blanking turns `gate` off and pulses `fault`, and it takes priority over a current trip on the same edge. Switching stays halted until `en` goes low and high again.
- R10: `fault` is high for exactly one cycle, and that cycle is the first cycle in which `gate` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable from the supervisor |
| demag_done | input | 1 | Secondary stroke finished |
| valley | input | 1 | Drain voltage at a valley |
| cs_trip | input | 1 | Peak-current comparator trip |
| sw_trip | input | 1 | Short-winding comparator trip |
| osc_ready | input | 1 | One-cycle oscillator grant pulse |
| gate | output | 1 | Primary switch gate command |
| fault | output | 1 | One-cycle fault pulse (on-time limit or short winding) |

## Verification
The checker assumes that `en` changes only at a clock edge: it never drops and returns between two edges. Under that assumption every fall of `gate` with `en` held high comes from the sequencer itself, and the on-time and off-time bounds can be checked against the parameters. The off-time bound is checked only between two strokes that ran under an unbroken enable, because the restart after a re-enable is shorter by design. The bench changes every input only on the falling edge and holds `en` for whole cycles, so it stays within these assumptions.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_BLANK,
        ST_ON,
        ST_SUPP,
        ST_DEMAG,
        ST_HALT
    } fsq_state_e;

    typedef struct packed {
        logic demag;
        logic valley;
        logic cs;
        logic sw;
        logic osc;
    } fsq_sense_t;

    typedef enum logic [1:0] {
        END_NONE,
        END_CS,
        END_LIMIT,
        END_SHORT
    } fsq_end_e;

    function automatic logic drives_gate(fsq_state_e s);
        return (s == ST_BLANK) || (s == ST_ON);
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int timer_width(int a, int b, int c);
        int w;
        w = $clog2(max3(a, b, c) + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/fsq_timer.sv
module fsq_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fsq_permit.sv
module fsq_permit (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic osc_pulse,
    input  logic consume,
    output logic granted
);
    logic ok_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ok_q <= 1'b0;
        end else if (consume) begin
            ok_q <= 1'b0;
        end else if (osc_pulse) begin
            ok_q <= 1'b1;
        end
    end

    assign granted = ok_q;
endmodule

// File: rtl/fsq_fsm.sv
module fsq_fsm
    import fsq_pkg::*;
#(
    parameter int LEB_CYC   = 4,
    parameter int MAXON_CYC = 40,
    parameter int SUPP_CYC  = 6,
    parameter int W         = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  fsq_sense_t   sense,
    input  logic         granted,
    input  logic         timer_zero,
    output fsq_state_e   state,
    output logic         load,
    output logic [W-1:0] load_val,
    output logic         consume,
    output fsq_end_e     end_kind
);
    localparam logic [W-1:0] LEB_LD  = W'(LEB_CYC - 1);
    localparam logic [W-1:0] ON_LD   = W'(MAXON_CYC - LEB_CYC - 1);
    localparam logic [W-1:0] SUPP_LD = W'(SUPP_CYC - 1);

    fsq_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        consume  = 1'b0;
        end_kind = END_NONE;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_ARM;
                ST_ARM: begin
                    if (granted && sense.valley) begin
                        state_d  = ST_BLANK;
                        load     = 1'b1;
                        load_val = LEB_LD;
                        consume  = 1'b1;
                    end
                end
                ST_BLANK: begin
                    if (timer_zero) begin
                        state_d  = ST_ON;
                        load     = 1'b1;
                        load_val = ON_LD;
                    end
                end
                ST_ON: begin
                    if (sense.sw) begin
                        state_d  = ST_HALT;
                        end_kind = END_SHORT;
                    end else if (sense.cs) begin
                        state_d  = ST_SUPP;
                        load     = 1'b1;
                        load_val = SUPP_LD;
                        end_kind = END_CS;
                    end else if (timer_zero) begin
                        state_d  = ST_HALT;
                        end_kind = END_LIMIT;
                    end
                end
                ST_SUPP: begin
                    if (timer_zero) state_d = ST_DEMAG;
                end
                ST_DEMAG: begin
                    if (sense.demag) state_d = ST_ARM;
                end
                ST_HALT: state_d = ST_HALT;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/flyback_stroke_seq.sv
module flyback_stroke_seq
    import fsq_pkg::*;
#(
    parameter int LEB_CYC   = 4,
    parameter int MAXON_CYC = 40,
    parameter int SUPP_CYC  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic demag_done,
    input  logic valley,
    input  logic cs_trip,
    input  logic sw_trip,
    input  logic osc_ready,
    output logic gate,
    output logic fault
);
    localparam int W = timer_width(LEB_CYC, MAXON_CYC, SUPP_CYC);

    fsq_sense_t   sense;
    fsq_state_e   state;
    fsq_end_e     end_kind;
    logic         granted, consume, load, tzero;
    logic [W-1:0] load_val;
    logic         fault_q;

    assign sense = '{demag: demag_done, valley: valley, cs: cs_trip,
                     sw: sw_trip, osc: osc_ready};

    fsq_permit u_permit (
        .clk(clk), .rst(rst), .en(en), .osc_pulse(sense.osc),
        .consume(consume), .granted(granted)
    );

    fsq_timer #(.W(W)) u_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .zero(tzero)
    );

    fsq_fsm #(
        .LEB_CYC(LEB_CYC), .MAXON_CYC(MAXON_CYC), .SUPP_CYC(SUPP_CYC), .W(W)
    ) u_fsm (
        .clk(clk), .rst(rst), .en(en), .sense(sense), .granted(granted),
        .timer_zero(tzero), .state(state), .load(load), .load_val(load_val),
        .consume(consume), .end_kind(end_kind)
    );

    always_ff @(posedge clk) begin
        if (rst) fault_q <= 1'b0;
        else     fault_q <= (end_kind == END_LIMIT) || (end_kind == END_SHORT);
    end

    assign gate  = drives_gate(state) && en;
    assign fault = fault_q;
endmodule

// File: rtl/fsq_chk.sv
module fsq_chk #(
    parameter int LEB_CYC   = 4,
    parameter int MAXON_CYC = 40,
    parameter int SUPP_CYC  = 6
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic valley,
    input logic gate,
    input logic fault
);
    localparam int HW = $clog2(MAXON_CYC + 2);
    localparam int LW = $clog2(SUPP_CYC + 3);
    localparam logic [HW-1:0] MAXON_L = HW'(MAXON_CYC);
    localparam logic [HW-1:0] MINON_L = HW'(LEB_CYC + 1);
    localparam logic [LW-1:0] OFF_L   = LW'(SUPP_CYC + 2);

    logic [HW-1:0] hi_len;
    logic [LW-1:0] lo_len;
    logic          clean;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len <= '0;
            lo_len <= '0;
            clean  <= 1'b0;
        end else if (gate) begin
            if (hi_len != '1) hi_len <= hi_len + 1'b1;
            lo_len <= '0;
            clean  <= en;
        end else begin
            hi_len <= '0;
            if (lo_len != '1) lo_len <= lo_len + 1'b1;
            clean  <= clean && en;
        end
    end

    // R2
    gate_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !gate);

    // R3
    rise_valley_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> $past(valley));

    // R8
    maxon_chk: assert property (@(posedge clk) disable iff (rst)
        gate |-> (hi_len < MAXON_L));

    // R6
    minon_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate) && en && $past(en)) |-> (hi_len >= MINON_L));

    // R5
    offtime_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate) && clean) |-> (lo_len >= OFF_L));

    // R10
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);

    // R10
    fault_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $fell(gate));
endmodule

bind flyback_stroke_seq fsq_chk #(
    .LEB_CYC(LEB_CYC), .MAXON_CYC(MAXON_CYC), .SUPP_CYC(SUPP_CYC)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .valley(valley), .gate(gate), .fault(fault)
);

// File: tb/flyback_stroke_seq_bench.sv
module flyback_stroke_seq_bench;
    localparam int LEB   = 4;
    localparam int MAXON = 40;
    localparam int SUPP  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1, en = 1'b0, demag = 1'b0, valley = 1'b0;
    logic cs = 1'b0, sw = 1'b0, osc = 1'b0;
    logic gate, fault;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    flyback_stroke_seq #(.LEB_CYC(LEB), .MAXON_CYC(MAXON), .SUPP_CYC(SUPP)) u_flyback_stroke_seq (
        .clk(clk), .rst(rst), .en(en), .demag_done(demag), .valley(valley),
        .cs_trip(cs), .sw_trip(sw), .osc_ready(osc), .gate(gate), .fault(fault)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; en = 0; demag = 0; valley = 0; cs = 0; sw = 0; osc = 0;
        cyc(3);
        rst = 0;
        cyc(1);
    endtask

    task automatic pulse_osc();
        osc = 1;
        cyc(1);
        osc = 0;
    endtask

    task automatic wait_rise(int lim, output int n);
        n = 0;
        while (!gate && n < lim) begin
            cyc(1);
            n++;
        end
    endtask

    task automatic high_width(output int w, output bit f);
        w = 0;
        while (gate && w < 1000) begin
            cyc(1);
            w++;
        end
        f = fault;
    endtask

    task automatic t_reset();
        rst = 1; en = 1; valley = 1; demag = 1; osc = 1;
        cyc(3);
        chk(gate == 0, "R1 gate in reset", int'(gate), 0);
        chk(fault == 0, "R1 fault in reset", int'(fault), 0);
        en = 0; osc = 0; rst = 0;
        cyc(1);
        pulse_osc();
        cyc(10);
        chk(gate == 0, "R1 idle without enable", int'(gate), 0);
    endtask

    task automatic t_enable_drop();
        int n;
        do_reset();
        en = 1; valley = 1;
        pulse_osc();
        wait_rise(10, n);
        cyc(2);
        en = 0;
        #1;
        chk(gate == 0, "R2 gate low same cycle", int'(gate), 0);
        cyc(3);
        chk(fault == 0, "R2 no fault on disable", int'(fault), 0);
        en = 1;
        cyc(8);
        chk(gate == 0, "R2 grant dropped", int'(gate), 0);
    endtask

    task automatic t_permit();
        do_reset();
        en = 1; demag = 1; valley = 1;
        cyc(20);
        chk(gate == 0, "R3 no grant no stroke", int'(gate), 0);
        valley = 0;
        pulse_osc();
        cyc(10);
        chk(gate == 0, "R3 no valley no stroke", int'(gate), 0);
        valley = 1;
        cyc(1);
        chk(gate == 1, "R3 valley starts stroke", int'(gate), 1);
    endtask

    task automatic t_blank();
        int n, w;
        bit f;
        do_reset();
        cs = 1; en = 1; valley = 1;
        pulse_osc();
        wait_rise(10, n);
        high_width(w, f);
        chk(w == LEB + 1, "R6 on-time with trip held", w, LEB + 1);
        chk(f == 0, "R7 current trip no fault", int'(f), 0);
        cs = 0;
        cyc(6);
        chk(gate == 0, "R7 stays off after trip release", int'(gate), 0);
    endtask

    task automatic t_suppress();
        int n;
        do_reset();
        demag = 1; cs = 1; en = 1; valley = 1;
        pulse_osc();
        wait_rise(10, n);
        osc = 1;
        cyc(1);
        osc = 0;
        while (gate) cyc(1);
        n = 0;
        while (!gate && n < 100) begin
            cyc(1);
            n++;
        end
        chk(n == SUPP + 2, "R5 off-time with all ready", n, SUPP + 2);
        demag = 0;
        pulse_osc();
        while (gate) cyc(1);
        cyc(30);
        chk(gate == 0, "R4 waits for demag", int'(gate), 0);
        demag = 1;
        wait_rise(10, n);
        chk(n == 2, "R4 rise after demag", n, 2);
    endtask

    task automatic t_maxon();
        int n, w;
        bit f;
        do_reset();
        en = 1; valley = 1;
        pulse_osc();
        wait_rise(10, n);
        chk(n == 1, "R3 first stroke without demag", n, 1);
        high_width(w, f);
        chk(w == MAXON, "R8 on-time limit", w, MAXON);
        chk(f == 1, "R10 fault with first low cycle", int'(f), 1);
        cyc(1);
        chk(fault == 0, "R10 fault one cycle", int'(fault), 0);
        demag = 1;
        pulse_osc();
        cyc(20);
        chk(gate == 0, "R8 halted after limit", int'(gate), 0);
    endtask

    task automatic t_short();
        int n, w;
        bit f;
        do_reset();
        sw = 1; cs = 1; en = 1; valley = 1;
        pulse_osc();
        wait_rise(10, n);
        high_width(w, f);
        chk(w == LEB + 1, "R9 short trip after blanking", w, LEB + 1);
        chk(f == 1, "R9 short trip fault priority", int'(f), 1);
        sw = 0; cs = 0; demag = 1;
        pulse_osc();
        cyc(20);
        chk(gate == 0, "R9 halted", int'(gate), 0);
        en = 0;
        cyc(1);
        en = 1;
        pulse_osc();
        wait_rise(10, n);
        chk(gate == 1, "R9 restart after enable cycle", int'(gate), 1);
    endtask

    initial begin
        t_reset();
        t_enable_drop();
        t_permit();
        t_blank();
        t_suppress();
        t_maxon();
        t_short();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule